// File: doc/BRIEF.md
# Four-Lane Carrier Frequency Offset De-rotator

This block removes a residual carrier frequency offset from a sample stream that arrives four samples per clock. A single phase accumulator steps once per clock, so one phase value serves a whole group of four samples. That phase is looked up in a combined cosine/sine table that stores only the first half of a quadrant. The rest of the circle is rebuilt by mirroring the table address, exchanging cosine and sine, and changing signs by quadrant. Four complex multipliers then apply the conjugate of the resulting phasor to the four lanes of the group at the same time.

The offset word is given as a per-sample phase step. Pulsing the load strobe captures that step and restarts the phase at zero. After the load, every valid group advances the phase by four steps. Groups that arrive without a valid flag leave the phase untouched. Results are rounded and clamped back to the input width, and they leave a fixed number of clocks after they enter.

Top module: `cfo_derotator`

## Requirements
- R1: While reset is held and after its release, before any valid group, `out_valid` is 0 and `out_i`/`out_q` are all zero.
- R2: A group presented with `in_valid`=1 before rising edge n appears on the outputs, with `out_valid`=1, after rising edge n+2 (three register stages), and `out_valid` is 0 in the cycles before and after it.
- R3: `freq_load`=1 latches `freq_word` as the per-sample step and resets the phase to 0; a valid group given in the same cycle as the load is rotated with phase 0.
- R4: Each valid group moves the 16-bit phase forward by 4×step, modulo 2^16 (negative steps wrap). Cycles without `in_valid` leave the phase unchanged.
- R5: All four lanes of one group, lane k at bits [12k+11:12k] of `in_i`/`in_q`, are rotated by the same phasor.
- R6: For phase p and lane input x = xi + j·xq, the output is x·e^(−jφ) with φ = 2π·(p[15:7] + 0.5)/512: out_i = xi·cos φ + xq·sin φ and out_q = xq·cos φ − xi·sin φ, each rounded to within 3 LSB.
- R7: p[15:14] selects the quadrant and p[13] selects the upper half of the quadrant. The table address p[12:7] is inverted when p[13]=1. The phasor is correct in all four quadrants and in both halves.
- R8: A result above 2047 becomes 2047 and one below −2048 becomes −2048 (two's-complement saturation to 12 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group is valid |
| in_i | input | 48 | Four signed 12-bit in-phase lanes, lane 0 in the low bits |
| in_q | input | 48 | Four signed 12-bit quadrature lanes |
| freq_word | input | 16 | Per-sample phase step, two's complement, 2^16 = one turn |
| freq_load | input | 1 | Latch `freq_word` and restart the phase at zero |
| out_valid | output | 1 | Output group is valid |
| out_i | output | 48 | De-rotated in-phase lanes |
| out_q | output | 48 | De-rotated quadrature lanes |

## Verification
Every result in this block is due on the third rising edge, counting the edge that samples the group. The phase snapshot is taken on that edge. The phasor is registered one edge later, and the product is registered on the edge after that. Each scenario drives its group at a falling edge and drops `in_valid` after the first rising edge. It then waits two more rising edges and samples one time unit later. The latency scenario also samples the edge before and the edge after, where `out_valid` must be low. The bench keeps its own phase from the load and step rules. It compares each lane with a floating-point rotation, allowing the stated rounding margin, and requires exact clamp values where saturation applies.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
    localparam real PI_R = 3.14159265358979;

    // Magnitude of cosine at the midpoint of table cell idx, scaled to 2^(cw-1)-1
    function automatic int tbl_cos(int idx, int abits, int cw);
        real ang;
        ang = (real'(idx) + 0.5) * (PI_R / 4.0) / real'(2 ** abits);
        return $rtoi($cos(ang) * real'((2 ** (cw - 1)) - 1) + 0.5);
    endfunction

    function automatic int tbl_sin(int idx, int abits, int cw);
        real ang;
        ang = (real'(idx) + 0.5) * (PI_R / 4.0) / real'(2 ** abits);
        return $rtoi($sin(ang) * real'((2 ** (cw - 1)) - 1) + 0.5);
    endfunction
endpackage

// File: rtl/cfo_phase_acc.sv
module cfo_phase_acc #(
    parameter int PW    = 16,
    parameter int LANES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          load,
    input  logic [PW-1:0] step_in,
    output logic [PW-1:0] phase_use,
    output logic [PW-1:0] phase_now
);
    localparam int LSH = $clog2(LANES);

    logic [PW-1:0] acc_q;
    logic [PW-1:0] inc_q;
    logic [PW-1:0] inc_use;

    always_comb begin
        phase_use = load ? '0 : acc_q;
        inc_use   = load ? step_in : inc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            inc_q <= '0;
        end else begin
            if (load) inc_q <= step_in;
            if (advance)   acc_q <= phase_use + PW'(inc_use << LSH);
            else if (load) acc_q <= '0;
        end
    end

    assign phase_now = acc_q;
endmodule

// File: rtl/cfo_sincos.sv
module cfo_sincos #(
    parameter int TA = 6,
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TA+2:0]        ang,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    localparam int DEPTH = 2 ** TA;

    logic [CW-1:0] rom_c [DEPTH];
    logic [CW-1:0] rom_s [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom_c[g] = CW'(cfo_pkg::tbl_cos(g, TA, CW));
        assign rom_s[g] = CW'(cfo_pkg::tbl_sin(g, TA, CW));
    end

    logic [1:0]           quad;
    logic                 half;
    logic [TA-1:0]        idx;
    logic signed [CW-1:0] bc, bs, mc, ms;

    always_comb begin
        quad = ang[TA+2:TA+1];
        half = ang[TA];
        idx  = half ? ~ang[TA-1:0] : ang[TA-1:0];
        bc   = $signed(half ? rom_s[idx] : rom_c[idx]);
        bs   = $signed(half ? rom_c[idx] : rom_s[idx]);
        unique case (quad)
            2'd0: begin mc =  bc; ms =  bs; end
            2'd1: begin mc = -bs; ms =  bc; end
            2'd2: begin mc = -bc; ms = -bs; end
            default: begin mc =  bs; ms = -bc; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            cos_o <= mc;
            sin_o <= ms;
        end
    end
endmodule

// File: rtl/cfo_cmul_sat.sv
module cfo_cmul_sat #(
    parameter int SW = 12,
    parameter int CW = 12
) (
    input  logic signed [SW-1:0] xi,
    input  logic signed [SW-1:0] xq,
    input  logic signed [CW-1:0] pc,
    input  logic signed [CW-1:0] ps,
    output logic signed [SW-1:0] yi,
    output logic signed [SW-1:0] yq
);
    localparam int XW = SW + CW + 1;
    localparam logic signed [XW-1:0] HI   = XW'((1 <<< (SW - 1)) - 1);
    localparam logic signed [XW-1:0] LO   = -HI - XW'(1);
    localparam logic signed [XW-1:0] HALF = XW'(1 <<< (CW - 2));

    logic signed [XW-1:0] si, sq, ri, rq;

    function automatic logic signed [SW-1:0] clamp(input logic signed [XW-1:0] v);
        if (v > HI)      return HI[SW-1:0];
        else if (v < LO) return LO[SW-1:0];
        else             return v[SW-1:0];
    endfunction

    always_comb begin
        si = XW'(xi) * XW'(pc) + XW'(xq) * XW'(ps);
        sq = XW'(xq) * XW'(pc) - XW'(xi) * XW'(ps);
        ri = (si + HALF) >>> (CW - 1);
        rq = (sq + HALF) >>> (CW - 1);
        yi = clamp(ri);
        yq = clamp(rq);
    end
endmodule

// File: rtl/cfo_derotator.sv
module cfo_derotator #(
    parameter int LANES = 4,
    parameter int SW    = 12,
    parameter int PW    = 16,
    parameter int TA    = 6,
    parameter int CW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*SW-1:0]   in_i,
    input  logic [LANES*SW-1:0]   in_q,
    input  logic [PW-1:0]         freq_word,
    input  logic                  freq_load,
    output logic                  out_valid,
    output logic [LANES*SW-1:0]   out_i,
    output logic [LANES*SW-1:0]   out_q
);
    localparam int AW = TA + 3;

    logic [PW-1:0]         phase_use, acc_now;
    logic [AW-1:0]         s1_ang;
    logic                  s1_valid, s2_valid;
    logic [LANES*SW-1:0]   s1_i, s1_q, s2_i, s2_q, y_i, y_q;
    logic signed [CW-1:0]  ph_cos, ph_sin;

    cfo_phase_acc #(.PW(PW), .LANES(LANES)) u_acc (
        .clk(clk), .rst_n(rst_n), .advance(in_valid), .load(freq_load),
        .step_in(freq_word), .phase_use(phase_use), .phase_now(acc_now)
    );

    // Stage 1: samples and phase snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_ang   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_i     <= in_i;
            s1_q     <= in_q;
            s1_ang   <= phase_use[PW-1 -: AW];
        end
    end

    // Stage 2: phasor lookup (registered inside) alongside sample delay
    cfo_sincos #(.TA(TA), .CW(CW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .ang(s1_ang), .cos_o(ph_cos), .sin_o(ph_sin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_i     <= '0;
            s2_q     <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_i     <= s1_i;
            s2_q     <= s1_q;
        end
    end

    // Stage 3: one shared phasor, one multiplier per lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cfo_cmul_sat #(.SW(SW), .CW(CW)) u_mul (
            .xi(s2_i[l*SW +: SW]), .xq(s2_q[l*SW +: SW]),
            .pc(ph_cos), .ps(ph_sin),
            .yi(y_i[l*SW +: SW]), .yq(y_q[l*SW +: SW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= s2_valid;
            out_i     <= y_i;
            out_q     <= y_q;
        end
    end
endmodule

// File: rtl/cfo_derotator_chk.sv
module cfo_derotator_chk #(
    parameter int PW = 16,
    parameter int AW = 9,
    parameter int CW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 freq_load,
    input logic                 out_valid,
    input logic [PW-1:0]        acc_phase,
    input logic [AW-1:0]        s1_ang,
    input logic signed [CW-1:0] ph_cos,
    input logic signed [CW-1:0] ph_sin
);
    localparam int AMP = (2 ** (CW - 1)) - 1;
    localparam int LOM = (AMP - 2) * (AMP - 2);
    localparam int HIM = (AMP + 2) * (AMP + 2);

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    int mag;
    assign mag = int'(ph_cos) * int'(ph_cos) + int'(ph_sin) * int'(ph_sin);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_load && !in_valid) |=> (acc_phase == '0)); // R3

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !freq_load) |=> $stable(acc_phase)); // R4

    AST_PHASOR_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (mag >= LOM && mag <= HIM)); // R6

    AST_QUAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |->
        (($past(s1_ang[AW-1:AW-2]) == 2'd0) ? (ph_cos > 0 && ph_sin > 0) :
         ($past(s1_ang[AW-1:AW-2]) == 2'd1) ? (ph_cos < 0 && ph_sin > 0) :
         ($past(s1_ang[AW-1:AW-2]) == 2'd2) ? (ph_cos < 0 && ph_sin < 0) :
                                             (ph_cos > 0 && ph_sin < 0))); // R7
endmodule

bind cfo_derotator cfo_derotator_chk #(.PW(PW), .AW(TA + 3), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .freq_load(freq_load),
    .out_valid(out_valid), .acc_phase(acc_now), .s1_ang(s1_ang),
    .ph_cos(ph_cos), .ph_sin(ph_sin)
);

// File: tb/test_cfo_derotator.sv
module test_cfo_derotator;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_i = '0;
    logic [47:0] in_q = '0;
    logic [15:0] freq_word = '0;
    logic        freq_load = 1'b0;
    logic        out_valid;
    logic [47:0] out_i, out_q;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] bm_phase = '0;
    logic [15:0] bm_inc = '0;
    int xi_v [4];
    int xq_v [4];

    always #2.5 clk = ~clk;

    cfo_derotator i_cfo_derotator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .freq_word(freq_word), .freq_load(freq_load),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    task automatic check(input string req, input int got, input int exp, input int tol);
        int d;
        n_chk++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(input int a, input int b, input real ang, input bit qpart);
        real c, s, v;
        c = $cos(ang) * 2047.0 / 2048.0;
        s = $sin(ang) * 2047.0 / 2048.0;
        v = qpart ? (real'(b) * c - real'(a) * s) : (real'(a) * c + real'(b) * s);
        v = $floor(v + 0.5);
        if (v > 2047.0) v = 2047.0;
        if (v < -2048.0) v = -2048.0;
        return $rtoi(v);
    endfunction

    function automatic int lane(input logic [47:0] v, input int k);
        return int'($signed(v[k*12 +: 12]));
    endfunction

    // Drive one group, model its phase, check the outputs three edges later
    task automatic run_group(input string req, input bit ld, input logic [15:0] fw);
        logic [15:0] p;
        real ang;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_i[k*12 +: 12] = 12'(xi_v[k]);
            in_q[k*12 +: 12] = 12'(xq_v[k]);
        end
        in_valid = 1'b1;
        freq_load = ld;
        freq_word = fw;
        if (ld) begin bm_inc = fw; p = 16'd0; end
        else p = bm_phase;
        bm_phase = p + (bm_inc << 2);
        @(posedge clk); #1;
        in_valid = 1'b0;
        freq_load = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        ang = 2.0 * 3.14159265358979 * (real'(p[15:7]) + 0.5) / 512.0;
        check({req, " valid"}, int'(out_valid), 1, 0);
        for (int k = 0; k < 4; k++) begin
            check({req, " i"}, lane(out_i, k), model(xi_v[k], xq_v[k], ang, 0), 3);
            check({req, " q"}, lane(out_q, k), model(xi_v[k], xq_v[k], ang, 1), 3);
        end
    endtask

    task automatic load_only(input logic [15:0] fw);
        @(negedge clk);
        freq_load = 1'b1;
        freq_word = fw;
        bm_inc = fw;
        bm_phase = '0;
        @(negedge clk);
        freq_load = 1'b0;
    endtask

    task automatic set_lanes(input int a0, input int b0, input int a1, input int b1,
                             input int a2, input int b2, input int a3, input int b3);
        xi_v[0] = a0; xq_v[0] = b0; xi_v[1] = a1; xq_v[1] = b1;
        xi_v[2] = a2; xq_v[2] = b2; xi_v[3] = a3; xq_v[3] = b3;
    endtask

    task automatic t_reset;
        #1;
        check("R1 valid in reset", int'(out_valid), 0, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 valid after reset", int'(out_valid), 0, 0);
        check("R1 out_i zero", int'(out_i != 0), 0, 0);
        check("R1 out_q zero", int'(out_q != 0), 0, 0);
    endtask

    task automatic t_latency;
        set_lanes(500, 0, 0, 0, 0, 0, 0, 0);
        load_only(16'd0);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_i[k*12 +: 12] = 12'(xi_v[k]);
            in_q[k*12 +: 12] = 12'(xq_v[k]);
        end
        in_valid = 1'b1;
        @(posedge clk); #1 in_valid = 1'b0;
        check("R2 low after edge n", int'(out_valid), 0, 0);
        @(posedge clk); #1;
        check("R2 low after edge n+1", int'(out_valid), 0, 0);
        @(posedge clk); #1;
        check("R2 high after edge n+2", int'(out_valid), 1, 0);
        check("R2 data aligned", lane(out_i, 0), model(500, 0, 2.0 * 3.14159265358979 * 0.5 / 512.0, 0), 3);
        @(posedge clk); #1;
        check("R2 low after edge n+3", int'(out_valid), 0, 0);
        bm_phase = '0;
    endtask

    task automatic t_load_with_group;
        set_lanes(1000, 0, -700, 300, 0, 1500, 1200, -1200);
        run_group("R3 load+valid phase0", 1'b1, 16'h0400);
        run_group("R3 next group 4x step", 1'b0, 16'h0000);
    endtask

    task automatic t_sweep;
        // Step 0x0B00: 4x = 11264 per group, walks every quadrant and half (R7)
        set_lanes(300, -200, -1500, 700, 0, 1800, 2000, -1900);
        load_only(16'h0B00);
        for (int g = 0; g < 12; g++) begin
            run_group("R4 R5 R7 sweep", 1'b0, 16'h0000);
            if (g % 3 == 1) repeat (2) @(negedge clk); // idle gap, phase must hold
        end
    endtask

    task automatic t_negative;
        set_lanes(1024, 512, -256, -1024, 800, -800, -2000, 100);
        load_only(16'hFEDD);
        for (int g = 0; g < 5; g++) run_group("R4 R6 negative step", 1'b0, 16'h0000);
    endtask

    task automatic t_reload;
        set_lanes(1700, 200, 0, -1700, -900, -900, 400, 1600);
        load_only(16'h0733);
        run_group("R4 before reload", 1'b0, 16'h0000);
        run_group("R4 before reload", 1'b0, 16'h0000);
        run_group("R3 reload mid-stream", 1'b1, 16'h1111);
        run_group("R3 after reload", 1'b0, 16'h0000);
    endtask

    task automatic t_saturate;
        // Phase 8192 -> angle near 45 deg: (2047,2047) rotates past full scale
        set_lanes(2047, 2047, -2048, -2048, 2047, 2047, 100, 100);
        load_only(16'd2048);
        run_group("R8 skip group", 1'b0, 16'h0000);
        run_group("R8 saturate", 1'b0, 16'h0000);
        check("R8 positive clamp", lane(out_i, 0), 2047, 0);
        check("R8 negative clamp", lane(out_i, 1), -2048, 0);
        check("R8 positive clamp lane2", lane(out_i, 2), 2047, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_load_with_group();
        t_sweep();
        t_negative();
        t_reload();
        t_saturate();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule